// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It implements a small integer subset: unsigned register add and subtract, OR with a zero-extended immediate, word load, word store, and branch when two registers are equal. A program counter addresses a private instruction store. A 32-entry register file supplies two operands. A three-function ALU (add, subtract, OR) with a zero flag computes results, memory addresses and the branch compare. A separate data store serves loads and stores.

Both stores are filled by a preload port while the core is held in reset. Once reset is released, the core runs from address 0. Its retirement activity appears on trace outputs: the program counter, the register write enable, index and value, and the data store write enable, address and value. This lets a surrounding environment follow every architectural change.

Top module: `sc_core`

## Requirements
- R1: While `rst` is 1, the program counter is 0 after each rising edge, and neither `rf_we_o` nor `dm_we_o` is asserted.
- R2: With opcode bits [31:26] = 0x00, funct bits [5:0] = 0x21 writes R[rs]+R[rt] to register rd, and funct 0x23 writes R[rs]-R[rt] to register rd, both modulo 2^32. The fields are rs [25:21], rt [20:16] and rd [15:11].
- R3: Opcode 0x0D writes R[rs] OR the zero-extended bits [15:0] to register rt.
- R4: Opcode 0x23 writes to register rt the data word at index bits [DMEM_AW+1:2] of R[rs]+sign_ext(imm16).
- R5: Opcode 0x2B writes R[rt] into the data word at index bits [DMEM_AW+1:2] of R[rs]+sign_ext(imm16). It does not write the register file.
- R6: Opcode 0x04 sets the PC to PC+4+(sign_ext(imm16)<<2) when R[rs] equals R[rt], and to PC+4 otherwise. The PC stays word aligned.
- R7: Every instruction other than a taken branch advances the PC by 4. The instruction is fetched from index bits [IMEM_AW+1:2] of the PC.
- R8: Register 0 reads as zero. An instruction whose destination is register 0 leaves `rf_we_o` low.
- R9: An opcode outside the set above, or opcode 0x00 with a funct other than 0x21 or 0x23, writes nothing and advances the PC by 4.
- R10: An instruction that names its destination as a source reads the value held before the instruction. The new value is visible to the next instruction.
- R11: When `ld_we` is 1, `ld_data` is written at the rising edge into word `ld_addr` of the instruction store (`ld_to_dmem` = 0) or of the data store (`ld_to_dmem` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Preload write strobe |
| ld_to_dmem | input | 1 | Preload target: 1 data store, 0 instruction store |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | Data store write this cycle |
| dm_addr_o | output | 32 | Byte address computed for load or store |
| dm_wdata_o | output | 32 | Value stored |

## Verification
Two functions meet in one cycle when an instruction both reads and writes the same register. The register file must return the old operand while the new value waits for the edge. Generated programs provoke this by drawing a destination equal to a source and by chaining such instructions with loads and branches that consume the result. A bench-side instruction model holds its own register and data state, and compares the write index, the value and the next PC cycle by cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rd;
        logic    ext_sign;
        logic    use_imm;
        alu_op_e alu_op;
        logic    mem_wr;
        logic    mem_rd;
        logic    branch;
    } ctrl_t;

    typedef struct packed {
        logic [31:0] pc;
    } core_st_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU || funct == FN_SUBU) begin
                    ctrl.reg_wr = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.alu_op = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OP_ORI: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OP_LW: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_rd   = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_SUB;
                ctrl.branch   = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int W       = 32,
    parameter int AW      = 6,
    localparam int DEPTH  = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ld_to_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dm_we_o,
    output logic [31:0]      dm_addr_o,
    output logic [31:0]      dm_wdata_o
);
    localparam int W = 32;

    core_st_t st_d, st_q;

    logic [W-1:0] instr;
    logic [5:0]   op, funct;
    logic [4:0]   rs, rt, rd, wb_addr;
    logic [15:0]  imm;
    ctrl_t        ctrl;
    logic [W-1:0] rd1, rd2, ext_imm, alu_b, alu_y, dm_rdata, wb_data;
    logic         alu_zero, take_br, rf_we, dm_we;
    logic         dld_we;
    logic [DMEM_AW-1:0] dm_waddr;
    logic [W-1:0] dm_wdata;

    assign op    = instr[31:26];
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign funct = instr[5:0];
    assign imm   = instr[15:0];

    sc_mem #(.W(W), .AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (ld_we && !ld_to_dmem),
        .waddr (ld_addr[IMEM_AW-1:0]),
        .wdata (ld_data),
        .raddr (st_q.pc[IMEM_AW+1:2]),
        .rdata (instr)
    );

    sc_decode u_dec (
        .op    (op),
        .funct (funct),
        .ctrl  (ctrl)
    );

    sc_regfile #(.W(W), .NREG(32)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (rs),
        .ra2   (rt),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    always_comb begin
        ext_imm = ctrl.ext_sign ? {{16{imm[15]}}, imm} : {16'h0000, imm};
        alu_b   = ctrl.use_imm ? ext_imm : rd2;
    end

    sc_alu #(.W(W)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        dld_we   = ld_we && ld_to_dmem;
        dm_we    = ctrl.mem_wr && !rst;
        dm_waddr = dld_we ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
        dm_wdata = dld_we ? ld_data : rd2;
    end

    sc_mem #(.W(W), .AW(DMEM_AW)) u_dmem (
        .clk   (clk),
        .we    (dm_we || dld_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (dm_rdata)
    );

    always_comb begin
        wb_addr = ctrl.dst_rd ? rd : rt;
        wb_data = ctrl.mem_rd ? dm_rdata : alu_y;
        rf_we   = ctrl.reg_wr && !rst && (wb_addr != 5'd0);
        take_br = ctrl.branch && alu_zero;
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (take_br) begin
            st_d.pc = st_q.pc + 32'd4 + {ext_imm[29:0], 2'b00};
        end else begin
            st_d.pc = st_q.pc + 32'd4;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wb_addr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        dm_we,
    input logic        take_br
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_PC: assert (pc == 32'd0); // R1
        end
        if (rst === 1'b1) begin
            AST_QUIET_IN_RESET: assert (!rf_we && !dm_we); // R1
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(take_br)) |-> (pc == $past(pc) + 32'd4)); // R7

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00); // R6

    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != 5'd0)); // R8

    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && dm_we)); // R5
endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_o),
    .rf_we    (rf_we_o),
    .rf_waddr (rf_waddr_o),
    .dm_we    (dm_we_o),
    .take_br  (take_br)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;
    localparam int RUN   = 300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic          ld_to_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic          rf_we_o, dm_we_o;
    logic [4:0]    rf_waddr_o;

    int total = 0;
    int bad = 0;
    int taken = 0;

    logic [31:0] m_rf [32];
    logic [31:0] m_dm [WORDS];
    logic [31:0] m_im [WORDS];
    logic [31:0] m_pc;
    logic [31:0] seed;

    always #4 clk = ~clk;

    sc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) u0 (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_to_dmem(ld_to_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] mk_r(logic [4:0] s, logic [4:0] t,
                                         logic [4:0] d, logic [5:0] f);
        return {6'h00, s, t, d, 5'd0, f};
    endfunction

    function automatic logic [31:0] mk_i(logic [5:0] o, logic [4:0] s,
                                         logic [4:0] t, logic [15:0] im);
        return {o, s, t, im};
    endfunction

    task automatic build_program();
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] r;
            logic [4:0]  s, t, d;
            logic [15:0] im, br;
            r  = rnd();
            s  = {2'b00, r[2:0]};
            t  = {2'b00, r[5:3]};
            d  = {2'b00, r[8:6]};
            im = r[31:16];
            br = {{12{r[19]}}, r[19:16]};
            if (i < 7) begin
                m_im[i] = mk_i(6'h0D, 5'd0, 5'(i + 1), im);
            end else begin
                case (r[12:9] % 4'd12)
                    4'd0:  m_im[i] = mk_r(s, t, d, 6'h21);
                    4'd1:  m_im[i] = mk_r(s, t, d, 6'h23);
                    4'd2:  m_im[i] = mk_i(6'h0D, s, t, im);
                    4'd3:  m_im[i] = mk_i(6'h23, s, t, im);
                    4'd4:  m_im[i] = mk_i(6'h2B, s, t, im);
                    4'd5:  m_im[i] = mk_i(6'h04, s, t, br);
                    4'd6:  m_im[i] = mk_i(6'h04, s, s, br);
                    4'd7:  m_im[i] = mk_i(6'h3F, s, t, im);
                    4'd8:  m_im[i] = {6'h00, s, t, d, r[24:20], 6'h20};
                    4'd9:  m_im[i] = mk_r(s, t, 5'd0, 6'h21);
                    4'd10: m_im[i] = mk_r(s, t, s, 6'h23);
                    default: m_im[i] = mk_r(d, d, d, 6'h21);
                endcase
            end
        end
        for (int i = 0; i < WORDS; i++) begin
            m_dm[i] = rnd();
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 2 * WORDS; i++) begin
            @(negedge clk);
            ld_we      = 1'b1;
            ld_to_dmem = (i >= WORDS);
            ld_addr    = AW'(i % WORDS);
            ld_data    = (i >= WORDS) ? m_dm[i - WORDS] : m_im[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        #1;
        chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(!rf_we_o, "R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        chk(!dm_we_o, "R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);
    endtask

    task automatic step();
        logic [31:0] ins, a, b, sx, zx, addr, npc, wd;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, wa;
        logic        ewe, edwe;
        string       tag;
        ins  = m_im[m_pc[AW+1:2]];
        op   = ins[31:26];
        rs   = ins[25:21];
        rt   = ins[20:16];
        rd   = ins[15:11];
        fn   = ins[5:0];
        a    = (rs == 5'd0) ? 32'd0 : m_rf[rs];
        b    = (rt == 5'd0) ? 32'd0 : m_rf[rt];
        sx   = {{16{ins[15]}}, ins[15:0]};
        zx   = {16'h0000, ins[15:0]};
        addr = a + sx;
        npc  = m_pc + 32'd4;
        ewe  = 1'b0;
        edwe = 1'b0;
        wa   = 5'd0;
        wd   = 32'd0;
        tag  = "R9";
        chk(pc_o == m_pc, "R7", "pc", pc_o, m_pc);
        if (op == 6'h00 && (fn == 6'h21 || fn == 6'h23)) begin
            wa  = rd;
            wd  = (fn == 6'h21) ? a + b : a - b;
            ewe = 1'b1;
            tag = "R2";
            if (rd != 5'd0 && (rd == rs || rd == rt)) tag = "R10";
        end else if (op == 6'h0D) begin
            wa = rt; wd = a | zx; ewe = 1'b1; tag = "R3";
        end else if (op == 6'h23) begin
            wa = rt; wd = m_dm[addr[AW+1:2]]; ewe = 1'b1; tag = "R4 R11";
        end else if (op == 6'h2B) begin
            edwe = 1'b1; tag = "R5";
        end else if (op == 6'h04) begin
            tag = "R6";
            if (a == b) begin
                npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
                taken++;
            end
        end
        if (ewe && wa == 5'd0) begin
            ewe = 1'b0;
            tag = "R8";
        end
        chk(rf_we_o == ewe, tag, "rf_we", {31'd0, rf_we_o}, {31'd0, ewe});
        if (ewe) begin
            chk(rf_waddr_o == wa, tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
            chk(rf_wdata_o == wd, tag, "rf_wdata", rf_wdata_o, wd);
            m_rf[wa] = wd;
        end
        chk(dm_we_o == edwe, tag, "dm_we", {31'd0, dm_we_o}, {31'd0, edwe});
        if (edwe) begin
            chk(dm_addr_o == addr, "R5", "dm_addr", dm_addr_o, addr);
            chk(dm_wdata_o == b, "R5", "dm_wdata", dm_wdata_o, b);
            m_dm[addr[AW+1:2]] = b;
        end
        m_pc = npc;
    endtask

    task automatic run_seed(input logic [31:0] s);
        seed = s;
        build_program();
        @(negedge clk);
        rst = 1'b1;
        preload();
        m_pc = 32'd0;
        rst  = 1'b0;
        for (int c = 0; c < RUN; c++) begin
            #1;
            step();
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        run_seed(32'h1234_5679);
        run_seed(32'hC0DE_0BAD);
        run_seed(32'h0F0F_7731);
        chk(taken > 0, "R6", "taken branch count", taken, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule